// File: doc/BRIEF.md
# Sector Erase Batch Collector

This block gathers the set of sectors that one sector erase will clear. The command decoder hands it the first sector once the erase command sequence has completed. While a load window stays open the host may add further sectors by writing the append code at any address inside each new sector. The block keeps the selection as a one-hot-per-sector mask over 32 sectors of 64 KB, addressed by address bits 20..16.

A retriggerable inactivity timer decides when the batch is complete. Each accepted load restarts the timer. When the window has been quiet for the configured number of clock cycles, protected sectors are struck out of the mask. If sectors remain, the erase engine receives a one-cycle start pulse together with the final mask. A suspend write during the window closes it at once and flags the start as suspended. Any other write throws the batch away. Window status appears on status bit 3.

Top module: `ers_load_window`

## Requirements
- R1: After reset the block is idle: `busy_o`, `q3_o`, `win_open_o`, `erase_go_o`, `susp_o` and `abort_o` are 0, and `mask_o` is 0.
- R2: A `start_i` pulse while idle opens the window (`win_open_o`=1, `q3_o`=0, `busy_o`=1). `mask_o` then holds only bit `wr_sec_i` (address bits 20..16) of that cycle.
- R3: A write with data 30h, taken k clock edges after the previous accepted load with 1 ≤ k ≤ WIN_CYCLES, is accepted. It sets bit `wr_sec_i` in `mask_o` and restarts the window.
- R4: If no load is accepted for WIN_CYCLES edges after the last one, the window closes on that edge. For a non-empty final mask, `erase_go_o` is high for exactly the following cycle and `q3_o` becomes 1.
- R5: Any write during the window with data other than 30h or B0h pulses `abort_o`, returns the block to idle with `mask_o`=0, and no erase starts.
- R6: A write of B0h during the window closes it on that edge. `erase_go_o` and `susp_o` then pulse together in the next cycle.
- R7: At close, every sector whose group bit `prot_grp_i[sector/4]` (sector address bits 20..18) is 1 is cleared from `mask_o`. When `unprot_i` is 1, no sector is cleared.
- R8: If the mask is empty after R7, `erase_go_o` stays 0. `busy_o` and `q3_o` stay 1 for NULL_CYCLES cycles, and then the block is idle.
- R9: Once the erase has begun, `start_i` and all writes are ignored and `mask_o` is held. `erase_done_i` returns the block to idle with `mask_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Sector erase command completed; first sector on `wr_sec_i` |
| wr_i | input | 1 | Host write strobe during the window |
| wr_sec_i | input | SEC_W | Sector field of the write address (bits 20..16) |
| wr_data_i | input | 8 | Write data byte |
| prot_grp_i | input | 2**SEC_W/4 | Protection flag per group of four adjacent sectors |
| unprot_i | input | 1 | Temporary unprotect: ignore all protection flags |
| erase_done_i | input | 1 | Erase engine finished |
| mask_o | output | 2**SEC_W | Selected sectors (final mask after close) |
| erase_go_o | output | 1 | One-cycle erase start pulse |
| susp_o | output | 1 | Start is in suspended state (with `erase_go_o`) |
| abort_o | output | 1 | One-cycle pulse: batch discarded |
| win_open_o | output | 1 | Load window open |
| q3_o | output | 1 | Status bit 3: 0 in window, 1 once erase begun |
| busy_o | output | 1 | Block not idle |

## Verification
The assertions assume that `start_i` and `wr_i` are single-cycle strobes from a decoder that never raises both in one cycle. They also assume that `erase_done_i` comes only while an erase is running and that the protection inputs hold steady across a window close. The stimulus drives every strobe for exactly one cycle on the falling clock edge. It holds `prot_grp_i` and `unprot_i` constant through each batch and raises `erase_done_i` only after the start pulse has been seen. The bench drives `start_i` and writes during a running erase on purpose, to show that they are ignored.

// File: rtl/ers_pkg.sv
package ers_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_RUN, ST_NULL} ers_state_e;
  typedef enum logic [1:0] {WK_NONE, WK_APPEND, WK_SUSP, WK_OTHER} wr_kind_e;
  localparam logic [7:0] CODE_APPEND = 8'h30;
  localparam logic [7:0] CODE_SUSP   = 8'hB0;
endpackage

// File: rtl/ers_wr_class.sv
module ers_wr_class
  import ers_pkg::*;
(
  input  logic       wr_i,
  input  logic [7:0] data_i,
  output wr_kind_e   kind_o
);
  always_comb begin
    if (!wr_i)                    kind_o = WK_NONE;
    else if (data_i == CODE_APPEND) kind_o = WK_APPEND;
    else if (data_i == CODE_SUSP)   kind_o = WK_SUSP;
    else                          kind_o = WK_OTHER;
  end
endmodule

// File: rtl/ers_win_timer.sv
module ers_win_timer #(
  parameter int WIN_CYCLES = 8000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic expire_o
);
  localparam int CW = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || restart_i) cnt_q <= '0;
    else if (cnt_q != LAST)      cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == LAST);

  // R4: quiet count never passes the window length
  a_r4_timer_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  // R3: an accepted load leaves the window freshly restarted
  a_r3_restart_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0));
endmodule

// File: rtl/ers_sel_accum.sv
module ers_sel_accum #(
  parameter int SEC_W     = 5,
  parameter int GRP_SHIFT = 2
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             clr_i,
  input  logic                             first_i,
  input  logic                             add_i,
  input  logic                             close_i,
  input  logic [SEC_W-1:0]                 sec_i,
  input  logic [(2**SEC_W>>GRP_SHIFT)-1:0] prot_grp_i,
  input  logic                             unprot_i,
  output logic [2**SEC_W-1:0]              mask_o,
  output logic                             masked_zero_o
);
  localparam int SECTORS = 2**SEC_W;

  logic [SECTORS-1:0] sel_q, onehot, prot_sec, masked;

  assign onehot = SECTORS'(1) << sec_i;

  for (genvar s = 0; s < SECTORS; s++) begin : g_prot
    assign prot_sec[s] = prot_grp_i[s >> GRP_SHIFT] & ~unprot_i;
  end

  assign masked        = sel_q & ~prot_sec;
  assign masked_zero_o = (masked == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sel_q <= '0;
    else if (clr_i)   sel_q <= '0;
    else if (first_i) sel_q <= onehot;
    else if (add_i)   sel_q <= sel_q | onehot;
    else if (close_i) sel_q <= masked;
  end

  assign mask_o = sel_q;

  // R7: nothing protected survives a close
  a_r7_no_protected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_i |=> ((sel_q & $past(prot_sec)) == '0));
  // R3: an add never drops a sector already held
  a_r3_add_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_i |=> ((sel_q & $past(sel_q)) == $past(sel_q)));
endmodule

// File: rtl/ers_win_fsm.sv
module ers_win_fsm
  import ers_pkg::*;
#(
  parameter int NULL_CYCLES = 200
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  wr_kind_e kind_i,
  input  logic     expire_i,
  input  logic     masked_zero_i,
  input  logic     erase_done_i,
  output logic     clr_o,
  output logic     first_o,
  output logic     add_o,
  output logic     close_o,
  output logic     restart_o,
  output logic     go_o,
  output logic     susp_o,
  output logic     abort_o,
  output logic     win_open_o,
  output logic     q3_o,
  output logic     busy_o
);
  localparam int NW = (NULL_CYCLES > 1) ? $clog2(NULL_CYCLES) : 1;
  localparam logic [NW-1:0] NLAST = NW'(NULL_CYCLES - 1);

  ers_state_e    state_q, state_d;
  logic [NW-1:0] ncnt_q, ncnt_d;
  logic          go_q, go_d, susp_q, susp_d, abort_q, abort_d;

  always_comb begin
    state_d   = state_q;
    ncnt_d    = ncnt_q;
    go_d      = 1'b0;
    susp_d    = 1'b0;
    abort_d   = 1'b0;
    clr_o     = 1'b0;
    first_o   = 1'b0;
    add_o     = 1'b0;
    close_o   = 1'b0;
    restart_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_LOAD;
        first_o = 1'b1;
      end
      ST_LOAD: begin
        if (kind_i == WK_APPEND) begin
          add_o     = 1'b1;
          restart_o = 1'b1;
        end else if (kind_i == WK_OTHER) begin
          clr_o   = 1'b1;
          abort_d = 1'b1;
          state_d = ST_IDLE;
        end else if (kind_i == WK_SUSP || expire_i) begin
          close_o = 1'b1;
          if (masked_zero_i) begin
            state_d = ST_NULL;
            ncnt_d  = '0;
          end else begin
            state_d = ST_RUN;
            go_d    = 1'b1;
            susp_d  = (kind_i == WK_SUSP);
          end
        end
      end
      ST_RUN: if (erase_done_i) begin
        clr_o   = 1'b1;
        state_d = ST_IDLE;
      end
      ST_NULL: begin
        if (ncnt_q == NLAST) state_d = ST_IDLE;
        else                 ncnt_d  = ncnt_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ncnt_q  <= '0;
      go_q    <= 1'b0;
      susp_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ncnt_q  <= ncnt_d;
      go_q    <= go_d;
      susp_q  <= susp_d;
      abort_q <= abort_d;
    end
  end

  assign go_o       = go_q;
  assign susp_o     = susp_q;
  assign abort_o    = abort_q;
  assign win_open_o = (state_q == ST_LOAD);
  assign q3_o       = (state_q == ST_RUN) || (state_q == ST_NULL);
  assign busy_o     = (state_q != ST_IDLE);

  // R5: a discarded batch lands in idle
  a_r5_abort_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_q |-> (state_q == ST_IDLE));
  // R8: the all-protected path never starts an erase
  a_r8_null_no_go: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_NULL) |-> !go_q);
  // R9: a running erase stays put until done
  a_r9_run_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !erase_done_i) |=> (state_q == ST_RUN));
endmodule

// File: rtl/ers_load_window.sv
module ers_load_window
  import ers_pkg::*;
#(
  parameter int SEC_W       = 5,
  parameter int GRP_SHIFT   = 2,
  parameter int WIN_CYCLES  = 8000,
  parameter int NULL_CYCLES = 200
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             start_i,
  input  logic                             wr_i,
  input  logic [SEC_W-1:0]                 wr_sec_i,
  input  logic [7:0]                       wr_data_i,
  input  logic [(2**SEC_W>>GRP_SHIFT)-1:0] prot_grp_i,
  input  logic                             unprot_i,
  input  logic                             erase_done_i,
  output logic [2**SEC_W-1:0]              mask_o,
  output logic                             erase_go_o,
  output logic                             susp_o,
  output logic                             abort_o,
  output logic                             win_open_o,
  output logic                             q3_o,
  output logic                             busy_o
);
  wr_kind_e kind;
  logic expire, masked_zero, clr, first, add, close, restart;

  ers_wr_class u_class (
    .wr_i   (wr_i),
    .data_i (wr_data_i),
    .kind_o (kind)
  );

  ers_win_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (win_open_o),
    .restart_i (restart),
    .expire_o  (expire)
  );

  ers_sel_accum #(.SEC_W(SEC_W), .GRP_SHIFT(GRP_SHIFT)) u_accum (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clr_i         (clr),
    .first_i       (first),
    .add_i         (add),
    .close_i       (close),
    .sec_i         (wr_sec_i),
    .prot_grp_i    (prot_grp_i),
    .unprot_i      (unprot_i),
    .mask_o        (mask_o),
    .masked_zero_o (masked_zero)
  );

  ers_win_fsm #(.NULL_CYCLES(NULL_CYCLES)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .kind_i        (kind),
    .expire_i      (expire),
    .masked_zero_i (masked_zero),
    .erase_done_i  (erase_done_i),
    .clr_o         (clr),
    .first_o       (first),
    .add_o         (add),
    .close_o       (close),
    .restart_o     (restart),
    .go_o          (erase_go_o),
    .susp_o        (susp_o),
    .abort_o       (abort_o),
    .win_open_o    (win_open_o),
    .q3_o          (q3_o),
    .busy_o        (busy_o)
  );

  // R4: start pulse lasts one cycle and comes with a non-empty mask
  a_r4_go_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_go_o |=> !erase_go_o);
  a_r4_go_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_go_o |-> (mask_o != '0));
  // R6: suspend flag only rides on a start
  a_r6_susp_with_go: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_o |-> erase_go_o);
  // R2: status bit 3 low whenever the window is open
  a_r2_q3_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_open_o |-> !q3_o);
  // R9: mask frozen once the erase has begun
  a_r9_mask_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q3_o && $past(q3_o)) |-> $stable(mask_o));
endmodule

// File: tb/ers_load_window_test.sv
module ers_load_window_test;
  localparam int SEC_W = 5;
  localparam int WIN   = 6;
  localparam int NULLC = 3;
  localparam int SECS  = 2**SEC_W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, wr_i = 1'b0, unprot_i = 1'b0, erase_done_i = 1'b0;
  logic [SEC_W-1:0] wr_sec_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] prot_grp_i = '0;
  logic [SECS-1:0] mask_o;
  logic erase_go_o, susp_o, abort_o, win_open_o, q3_o, busy_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ers_load_window #(.SEC_W(SEC_W), .GRP_SHIFT(2), .WIN_CYCLES(WIN),
                    .NULL_CYCLES(NULLC)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .wr_i(wr_i),
    .wr_sec_i(wr_sec_i), .wr_data_i(wr_data_i), .prot_grp_i(prot_grp_i),
    .unprot_i(unprot_i), .erase_done_i(erase_done_i), .mask_o(mask_o),
    .erase_go_o(erase_go_o), .susp_o(susp_o), .abort_o(abort_o),
    .win_open_o(win_open_o), .q3_o(q3_o), .busy_o(busy_o));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start(int sec);
    start_i = 1'b1; wr_sec_i = SEC_W'(sec);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic do_wr(int sec, logic [7:0] d);
    wr_i = 1'b1; wr_sec_i = SEC_W'(sec); wr_data_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic do_done();
    erase_done_i = 1'b1;
    @(negedge clk);
    erase_done_i = 1'b0;
  endtask

  function automatic logic [SECS-1:0] bit_of(int s);
    return SECS'(1) << s;
  endfunction

  initial begin
    wait_n(3);
    chk("R1 busy", busy_o, 0);
    chk("R1 q3", q3_o, 0);
    chk("R1 mask", mask_o, 0);
    chk("R1 pulses", {erase_go_o, susp_o, abort_o, win_open_o}, 0);
    rst_ni = 1'b1;
    wait_n(1);

    // R2 + R4: single sector, exact close cycle
    do_start(5);
    chk("R2 window", {win_open_o, q3_o, busy_o}, 3'b101);
    chk("R2 mask", mask_o, bit_of(5));
    wait_n(WIN - 1);
    chk("R4 still open", {win_open_o, erase_go_o}, 2'b10);
    wait_n(1);
    chk("R4 go", {erase_go_o, susp_o, q3_o, win_open_o}, 4'b1010);
    chk("R4 mask", mask_o, bit_of(5));
    wait_n(1);
    chk("R4 go one cycle", erase_go_o, 0);
    do_done();
    chk("R9 done idle", {busy_o, q3_o}, 0);
    chk("R9 mask cleared", mask_o, 0);

    // R3: boundary gap WIN, then gap 1; R9 ignored traffic
    do_start(3);
    wait_n(WIN - 1);
    do_wr(17, 8'h30);
    chk("R3 gap=WIN accepted", {win_open_o, mask_o[17]}, 2'b11);
    do_wr(31, 8'h30);
    chk("R3 mask", mask_o, bit_of(3) | bit_of(17) | bit_of(31));
    wait_n(WIN - 1);
    chk("R3 restarted", {win_open_o, erase_go_o}, 2'b10);
    wait_n(1);
    chk("R4 go after restart", erase_go_o, 1);
    do_start(9);
    do_wr(9, 8'h55);
    chk("R9 no abort", abort_o, 0);
    do_wr(9, 8'hB0);
    do_wr(12, 8'h30);
    chk("R9 mask held", mask_o, bit_of(3) | bit_of(17) | bit_of(31));
    chk("R9 still running", {q3_o, busy_o, win_open_o}, 3'b110);
    do_done();

    // R4: gap WIN+1 too late
    do_start(2);
    wait_n(WIN);
    chk("R4 closed before late load", erase_go_o, 1);
    do_wr(20, 8'h30);
    chk("R9 late load ignored", mask_o, bit_of(2));
    do_done();

    // R5: abort
    do_start(1);
    do_wr(8, 8'h30);
    do_wr(8, 8'h55);
    chk("R5 abort pulse", {abort_o, busy_o, win_open_o}, 3'b100);
    chk("R5 mask cleared", mask_o, 0);
    wait_n(WIN + 1);
    chk("R5 no go", {erase_go_o, busy_o}, 0);

    // R6: suspend
    do_start(2);
    wait_n(1);
    do_wr(10, 8'h30);
    do_wr(0, 8'hB0);
    chk("R6 go+susp", {erase_go_o, susp_o, q3_o}, 3'b111);
    chk("R6 mask", mask_o, bit_of(2) | bit_of(10));
    do_done();

    // R7: protection of group 1 (sectors 4..7)
    prot_grp_i = 8'h02;
    do_start(4);
    do_wr(5, 8'h30);
    do_wr(9, 8'h30);
    wait_n(WIN);
    chk("R7 masked", {erase_go_o, mask_o}, {1'b1, bit_of(9)});
    do_done();
    unprot_i = 1'b1;
    do_start(4);
    wait_n(WIN);
    chk("R7 unprotect", {erase_go_o, mask_o}, {1'b1, bit_of(4)});
    do_done();
    unprot_i = 1'b0;

    // R8: all protected
    do_start(6);
    wait_n(WIN);
    chk("R8 no go", {erase_go_o, q3_o, busy_o, mask_o}, {3'b011, {SECS{1'b0}}});
    wait_n(NULLC - 1);
    chk("R8 busy held", {q3_o, busy_o}, 2'b11);
    wait_n(1);
    chk("R8 idle", {q3_o, busy_o}, 0);
    // R8 via suspend on protected sector
    do_start(7);
    do_wr(0, 8'hB0);
    chk("R8 susp no go", {erase_go_o, susp_o, q3_o}, 3'b001);
    wait_n(NULLC);
    chk("R8 susp idle", busy_o, 0);

    // R7 sweep over all sectors, alternating protection
    prot_grp_i = 8'hA5;
    for (int s = 0; s < SECS; s++) begin
      automatic bit p = prot_grp_i[s >> 2];
      do_start(s);
      wait_n(WIN);
      chk("R7 sweep go", erase_go_o, !p);
      chk("R7 sweep mask", mask_o, p ? '0 : bit_of(s));
      if (p) wait_n(NULLC);
      else   do_done();
      chk("R9 sweep idle", busy_o, 0);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule